// File: doc/BRIEF.md
# Polyphase Scaler Factor Calculator

This block works out the two scale factors a layer scaler needs, one horizontal and one vertical, from a source size and a destination size. It also picks an upscale or downscale coefficient set for each axis. A caller presents the four sizes and a mode bit together with a one-cycle start pulse. After a fixed sequence the block raises a one-cycle done pulse. The scaler enable, both factors, both coefficient-set selects and an error flag are then valid, and they hold until the next job completes.

Two kinds of scaler are served. The polyphase kind divides a phase-corrected numerator by the destination size minus one. It then checks the last source position the factor would sample, and takes one off the factor if that position lies beyond the final source pixel. The plain ratio kind divides 1024 times the source size by the destination size. A single restoring divider, producing one quotient bit per cycle, is shared between the two axes. Sizes that would divide by zero are caught up front and reported through the error flag.

Top module: `scl_factor_calc`

## Requirements
- R1: While reset is held and immediately after it, `done`, `busy`, `scale_en`, `cfg_err`, `coef_down_x`, `coef_down_y`, `fact_x` and `fact_y` are all 0.
- R2: When the source equals the destination on both axes, the job finishes with `scale_en`=0, `fact_x`=`fact_y`=0 and `cfg_err`=0. This check takes precedence over the error conditions of R7.
- R3: In polyphase mode (`poly_mode`=1), each axis factor is floor((2048·(src−1) − 256·PHI_OFS) / (dst−1)), with PHI_OFS=4 on both axes, before the correction of R4.
- R4: In polyphase mode, if floor((factor·(dst−1) + 256·PHI_OFS) / 2048) exceeds src−1, the factor is reduced by one. A reported polyphase factor therefore never places that position beyond src−1.
- R5: In ratio mode (`poly_mode`=0), each axis factor is floor(1024·src / dst).
- R6: For each axis, `coef_down_*`=1 (downscale set) when dst < src, and 0 (upscale set) otherwise. This holds for every completed job.
- R7: If the job is not an identity (R2) and any axis has dst ≤ 1 or src = 0, or polyphase mode has an axis with 8·(src−1) < PHI_OFS, the job finishes with `cfg_err`=1, `scale_en`=0 and both factors 0.
- R8: `busy` is 1 from the cycle after an accepted start until the done cycle. A start pulse while `busy` is 1 is ignored: the running job's results are unchanged, and no extra done pulse follows.
- R9: `done` is a single-cycle pulse. All result outputs change only in a done cycle and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, accepted when not busy |
| poly_mode | input | 1 | 1 = polyphase scaler, 0 = ratio scaler |
| src_w | input | SIZE_W | Source width |
| src_h | input | SIZE_W | Source height |
| dst_w | input | SIZE_W | Destination width |
| dst_h | input | SIZE_W | Destination height |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| scale_en | output | 1 | Scaler enabled for this job |
| fact_x | output | SIZE_W+11 | Horizontal factor |
| fact_y | output | SIZE_W+11 | Vertical factor |
| coef_down_x | output | 1 | Horizontal coefficient set: 1 downscale, 0 upscale |
| coef_down_y | output | 1 | Vertical coefficient set: 1 downscale, 0 upscale |
| cfg_err | output | 1 | Job rejected because of sizes that cannot be divided |

## Verification
The bench builds the block with SIZE_W=10 and PHI_OFS=4. The largest size is then 1023, so the extreme quotients fit inside short runs. These include a 1023-to-2 polyphase shrink, whose factor nearly fills the 21-bit result, and a 1023-by-2 to 2-by-1023 ratio swap. The narrow width also makes the dst=1, src=0 and polyphase src=1 rejections easy to place next to legal neighbours, such as a 1-to-5 ratio enlargement and a 1-by-1 identity. The same configuration covers mixed-direction axes, single-axis identity, and a start pulse that arrives during a running division.

// File: rtl/scl_pkg.sv
package scl_pkg;

    // 256 * 8 = 2^11 for the polyphase numerator, 1024 = 2^10 for ratio
    localparam int POLY_SHIFT  = 11;
    localparam int RATIO_SHIFT = 10;
    localparam int PHASE_UNIT  = 256;
    localparam int AXIS_N      = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SORT,
        ST_LAUNCH,
        ST_WAIT,
        ST_CHECK,
        ST_FIN
    } scl_state_e;

    typedef enum logic [1:0] {
        KIND_SCALE,
        KIND_IDENT,
        KIND_ERR
    } scl_kind_e;

    // identity wins over a size fault; a fault wins over scaling
    function automatic scl_kind_e scl_classify(input logic ident_all,
                                               input logic bad_any);
        if (ident_all)
            return KIND_IDENT;
        else if (bad_any)
            return KIND_ERR;
        else
            return KIND_SCALE;
    endfunction

endpackage

// File: rtl/scl_axis_prep.sv
module scl_axis_prep
    import scl_pkg::*;
#(
    parameter int SIZE_W  = 12,
    parameter int PHI_OFS = 4,
    localparam int NUM_W  = SIZE_W + POLY_SHIFT
) (
    input  logic              poly,
    input  logic [SIZE_W-1:0] src,
    input  logic [SIZE_W-1:0] dst,
    output logic [NUM_W-1:0]  num,
    output logic [SIZE_W-1:0] den,
    output logic              same,
    output logic              bad,
    output logic              down
);

    localparam logic [NUM_W-1:0] PHASE_TERM = NUM_W'(PHI_OFS * PHASE_UNIT);

    logic [SIZE_W-1:0] src_m1;
    logic [NUM_W-1:0]  poly_num;
    logic [NUM_W-1:0]  ratio_num;
    logic              poly_short;

    assign src_m1    = src - SIZE_W'(1);
    assign poly_num  = (NUM_W'(src_m1) << POLY_SHIFT) - PHASE_TERM;
    assign ratio_num = NUM_W'(src) << RATIO_SHIFT;

    // 8*(src-1) < PHI  <=>  8*src < PHI + 8 (also true for src = 0)
    assign poly_short = (int'(src) * 8) < (PHI_OFS + 8);

    always_comb begin
        num  = poly ? poly_num : ratio_num;
        den  = poly ? (dst - SIZE_W'(1)) : dst;
        same = (src == dst);
        down = (dst < src);
        bad  = (dst <= SIZE_W'(1)) || (src == '0) || (poly && poly_short);
    end

endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
    parameter int NUM_W = 23,
    parameter int DEN_W = 12,
    localparam int CNT_W = $clog2(NUM_W + 1),
    localparam int PRD_W = NUM_W + DEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] q_q;
    logic [NUM_W-1:0] num_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   trial_sub;
    logic             fits;

    // shift the next dividend bit into the partial remainder
    assign trial     = {rem_q, q_q[NUM_W-1]};
    assign fits      = (trial >= {1'b0, den_q});
    assign trial_sub = trial - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            den_q  <= '0;
            q_q    <= '0;
            num_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                q_q    <= num;
                num_q  <= num;
                den_q  <= den;
                rem_q  <= '0;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (fits) begin
                    rem_q <= trial_sub[DEN_W-1:0];
                    q_q   <= {q_q[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[DEN_W-1:0];
                    q_q   <= {q_q[NUM_W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = q_q;

    // R3 / R5: the quotient and remainder reproduce the latched dividend
    a_r3_div_exact: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((PRD_W'(q_q) * PRD_W'(den_q) + PRD_W'(rem_q) == PRD_W'(num_q))
                    && (rem_q < den_q)));

    // R8: the controller never restarts a division in flight
    a_r8_start_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/scl_factor_calc.sv
module scl_factor_calc
    import scl_pkg::*;
#(
    parameter int SIZE_W  = 12,
    parameter int PHI_OFS = 4,
    localparam int NUM_W  = SIZE_W + POLY_SHIFT,
    localparam int CHK_W  = NUM_W + SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              poly_mode,
    input  logic [SIZE_W-1:0] src_w,
    input  logic [SIZE_W-1:0] src_h,
    input  logic [SIZE_W-1:0] dst_w,
    input  logic [SIZE_W-1:0] dst_h,
    output logic              busy,
    output logic              done,
    output logic              scale_en,
    output logic [NUM_W-1:0]  fact_x,
    output logic [NUM_W-1:0]  fact_y,
    output logic              coef_down_x,
    output logic              coef_down_y,
    output logic              cfg_err
);

    localparam logic [CHK_W-1:0] PHASE_TERM = CHK_W'(PHI_OFS * PHASE_UNIT);

    scl_state_e        state_q;
    scl_kind_e         kind_q;
    logic              poly_q;
    logic              ax_q;
    logic [SIZE_W-1:0] src_q [AXIS_N];
    logic [SIZE_W-1:0] dst_q [AXIS_N];
    logic [NUM_W-1:0]  fac_q [AXIS_N];
    logic [NUM_W-1:0]  cand_q;

    logic [NUM_W-1:0]  num_ax  [AXIS_N];
    logic [SIZE_W-1:0] den_ax  [AXIS_N];
    logic              same_ax [AXIS_N];
    logic              bad_ax  [AXIS_N];
    logic              down_ax [AXIS_N];

    logic              div_start;
    logic              div_busy;
    logic              div_done;
    logic [NUM_W-1:0]  div_quot;

    logic [CHK_W-1:0]  reach;
    logic              overshoot;

    // one operand former per axis, fed from the latched job
    for (genvar g = 0; g < AXIS_N; g++) begin : g_axis
        scl_axis_prep #(
            .SIZE_W  (SIZE_W),
            .PHI_OFS (PHI_OFS)
        ) u_prep (
            .poly (poly_q),
            .src  (src_q[g]),
            .dst  (dst_q[g]),
            .num  (num_ax[g]),
            .den  (den_ax[g]),
            .same (same_ax[g]),
            .bad  (bad_ax[g]),
            .down (down_ax[g])
        );
    end

    assign div_start = (state_q == ST_LAUNCH);

    scl_divider #(
        .NUM_W (NUM_W),
        .DEN_W (SIZE_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (num_ax[ax_q]),
        .den   (den_ax[ax_q]),
        .busy  (div_busy),
        .done  (div_done),
        .quot  (div_quot)
    );

    // last sampled source position for the candidate factor
    assign reach     = (CHK_W'(cand_q) * CHK_W'(dst_q[ax_q] - SIZE_W'(1)) + PHASE_TERM)
                       >> POLY_SHIFT;
    assign overshoot = reach > CHK_W'(src_q[ax_q] - SIZE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            kind_q      <= KIND_IDENT;
            poly_q      <= 1'b0;
            ax_q        <= 1'b0;
            cand_q      <= '0;
            for (int i = 0; i < AXIS_N; i++) begin
                src_q[i] <= '0;
                dst_q[i] <= '0;
                fac_q[i] <= '0;
            end
            done        <= 1'b0;
            scale_en    <= 1'b0;
            fact_x      <= '0;
            fact_y      <= '0;
            coef_down_x <= 1'b0;
            coef_down_y <= 1'b0;
            cfg_err     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        poly_q   <= poly_mode;
                        src_q[0] <= src_w;
                        src_q[1] <= src_h;
                        dst_q[0] <= dst_w;
                        dst_q[1] <= dst_h;
                        ax_q     <= 1'b0;
                        state_q  <= ST_SORT;
                    end
                end
                ST_SORT: begin
                    kind_q  <= scl_classify(same_ax[0] && same_ax[1],
                                            bad_ax[0] || bad_ax[1]);
                    fac_q[0] <= '0;
                    fac_q[1] <= '0;
                    if (scl_classify(same_ax[0] && same_ax[1],
                                     bad_ax[0] || bad_ax[1]) == KIND_SCALE)
                        state_q <= ST_LAUNCH;
                    else
                        state_q <= ST_FIN;
                end
                ST_LAUNCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (div_done) begin
                        cand_q  <= div_quot;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    fac_q[ax_q] <= (poly_q && overshoot) ? (cand_q - NUM_W'(1)) : cand_q;
                    if (ax_q) begin
                        state_q <= ST_FIN;
                    end else begin
                        ax_q    <= 1'b1;
                        state_q <= ST_LAUNCH;
                    end
                end
                ST_FIN: begin
                    scale_en    <= (kind_q == KIND_SCALE);
                    cfg_err     <= (kind_q == KIND_ERR);
                    fact_x      <= (kind_q == KIND_SCALE) ? fac_q[0] : '0;
                    fact_y      <= (kind_q == KIND_SCALE) ? fac_q[1] : '0;
                    coef_down_x <= down_ax[0];
                    coef_down_y <= down_ax[1];
                    done        <= 1'b1;
                    state_q     <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R8: the done cycle is never a busy cycle
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: results move only in a done cycle
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({scale_en, cfg_err, fact_x, fact_y, coef_down_x, coef_down_y}));

    // R7: a rejected job reports no scaling
    a_r7_err_off: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!scale_en && fact_x == '0 && fact_y == '0));

    // R4: a reported polyphase factor never samples past the last source pixel
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (rst)
        (done && scale_en && poly_q) |->
            (((CHK_W'(fact_x) * CHK_W'(dst_q[0] - SIZE_W'(1)) + PHASE_TERM) >> POLY_SHIFT)
                 <= CHK_W'(src_q[0] - SIZE_W'(1))) &&
            (((CHK_W'(fact_y) * CHK_W'(dst_q[1] - SIZE_W'(1)) + PHASE_TERM) >> POLY_SHIFT)
                 <= CHK_W'(src_q[1] - SIZE_W'(1))));

endmodule

// File: tb/scl_factor_calc_tb.sv
`timescale 1ns/1ps
module scl_factor_calc_tb;

    localparam int SIZE_W  = 10;
    localparam int PHI_OFS = 4;
    localparam int NUM_W   = SIZE_W + 11;
    localparam int NV      = 15;
    localparam int WATCHDOG = 150000;

    // stimulus: {poly, src_w, src_h, dst_w, dst_h}
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 10'd640,  10'd480,  10'd320, 10'd240},
        {1'b1, 10'd320,  10'd240,  10'd800, 10'd600},
        {1'b1, 10'd100,  10'd50,   10'd60,  10'd200},
        {1'b0, 10'd640,  10'd480,  10'd320, 10'd240},
        {1'b0, 10'd300,  10'd200,  10'd1000, 10'd700},
        {1'b0, 10'd1023, 10'd2,    10'd2,   10'd1023},
        {1'b1, 10'd1023, 10'd1023, 10'd2,   10'd2},
        {1'b1, 10'd123,  10'd45,   10'd123, 10'd45},
        {1'b1, 10'd50,   10'd50,   10'd50,  10'd60},
        {1'b1, 10'd200,  10'd100,  10'd1,   10'd50},
        {1'b0, 10'd200,  10'd0,    10'd100, 10'd50},
        {1'b1, 10'd1,    10'd100,  10'd10,  10'd50},
        {1'b0, 10'd100,  10'd100,  10'd1,   10'd20},
        {1'b0, 10'd1,    10'd1,    10'd5,   10'd5},
        {1'b1, 10'd1,    10'd1,    10'd1,   10'd1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              poly_mode = 1'b0;
    logic [SIZE_W-1:0] src_w = '0;
    logic [SIZE_W-1:0] src_h = '0;
    logic [SIZE_W-1:0] dst_w = '0;
    logic [SIZE_W-1:0] dst_h = '0;
    logic              busy;
    logic              done;
    logic              scale_en;
    logic [NUM_W-1:0]  fact_x;
    logic [NUM_W-1:0]  fact_y;
    logic              coef_down_x;
    logic              coef_down_y;
    logic              cfg_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    scl_factor_calc #(
        .SIZE_W  (SIZE_W),
        .PHI_OFS (PHI_OFS)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .poly_mode   (poly_mode),
        .src_w       (src_w),
        .src_h       (src_h),
        .dst_w       (dst_w),
        .dst_h       (dst_h),
        .busy        (busy),
        .done        (done),
        .scale_en    (scale_en),
        .fact_x      (fact_x),
        .fact_y      (fact_y),
        .coef_down_x (coef_down_x),
        .coef_down_y (coef_down_y),
        .cfg_err     (cfg_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint poly_factor(input longint s, input longint d);
        longint f;
        f = (2048 * (s - 1) - 256 * PHI_OFS) / (d - 1);
        if (((f * (d - 1) + 256 * PHI_OFS) / 2048) > (s - 1))
            f = f - 1;
        return f;
    endfunction

    function automatic bit poly_reach_ok(input longint f, input longint s, input longint d);
        return ((f * (d - 1) + 256 * PHI_OFS) / 2048) <= (s - 1);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic launch(input bit p, input int sx, input int sy, input int dx, input int dy);
        @(negedge clk);
        poly_mode = p;
        src_w = SIZE_W'(sx);
        src_h = SIZE_W'(sy);
        dst_w = SIZE_W'(dx);
        dst_h = SIZE_W'(dy);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (!done) check(req, 0, 1);
    endtask

    task automatic run_vector(input logic [40:0] v);
        bit     p;
        longint sx, sy, dx, dy;
        longint efx, efy;
        bit     ident, bad;
        string  tag;
        p  = v[40];
        sx = longint'(v[39:30]);
        sy = longint'(v[29:20]);
        dx = longint'(v[19:10]);
        dy = longint'(v[9:0]);
        ident = (sx == dx) && (sy == dy);
        bad   = (dx <= 1) || (dy <= 1) || (sx == 0) || (sy == 0) ||
                (p && ((8 * sx < PHI_OFS + 8) || (8 * sy < PHI_OFS + 8)));
        launch(p, int'(sx), int'(sy), int'(dx), int'(dy));
        wait_done("R9 done");
        if (ident) begin
            tag = "R2";
            check("R2 scale_en", scale_en, 0);
            check("R2 fact_x", fact_x, 0);
            check("R2 fact_y", fact_y, 0);
            check("R2 cfg_err", cfg_err, 0);
        end else if (bad) begin
            tag = "R7";
            check("R7 cfg_err", cfg_err, 1);
            check("R7 scale_en", scale_en, 0);
            check("R7 fact_x", fact_x, 0);
            check("R7 fact_y", fact_y, 0);
        end else if (p) begin
            efx = poly_factor(sx, dx);
            efy = poly_factor(sy, dy);
            check("R3 scale_en", scale_en, 1);
            check("R3 cfg_err", cfg_err, 0);
            check("R3 fact_x", fact_x, efx);
            check("R3 fact_y", fact_y, efy);
            check("R4 reach_x", poly_reach_ok(fact_x, sx, dx), 1);
            check("R4 reach_y", poly_reach_ok(fact_y, sy, dy), 1);
        end else begin
            efx = (1024 * sx) / dx;
            efy = (1024 * sy) / dy;
            check("R5 scale_en", scale_en, 1);
            check("R5 cfg_err", cfg_err, 0);
            check("R5 fact_x", fact_x, efx);
            check("R5 fact_y", fact_y, efy);
        end
        check("R6 coef_down_x", coef_down_x, (dx < sx) ? 1 : 0);
        check("R6 coef_down_y", coef_down_y, (dy < sy) ? 1 : 0);
        @(negedge clk);
        check("R9 done pulse", done, 0);
    endtask

    initial begin
        longint ax, ay;
        int     extra;
        repeat (3) @(negedge clk);
        // R1: outputs at rest during reset
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 scale_en", scale_en, 0);
        check("R1 fact_x", fact_x, 0);
        check("R1 fact_y", fact_y, 0);
        check("R1 cfg_err", cfg_err, 0);
        check("R1 coef_down_x", coef_down_x, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release busy", busy, 0);
        check("R1 after release done", done, 0);

        for (int i = 0; i < NV; i++) begin
            run_vector(VEC[i]);
        end

        // R8: busy through the run, second start ignored
        ax = poly_factor(640, 320);
        ay = poly_factor(480, 240);
        launch(1'b1, 640, 480, 320, 240);
        check("R8 busy after start", busy, 1);
        repeat (4) @(negedge clk);
        check("R8 busy mid run", busy, 1);
        poly_mode = 1'b0;
        src_w = 10'd10;
        src_h = 10'd10;
        dst_w = 10'd1000;
        dst_h = 10'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8 done");
        check("R8 busy in done cycle", busy, 0);
        check("R8 fact_x kept", fact_x, ax);
        check("R8 fact_y kept", fact_y, ay);
        check("R8 scale_en kept", scale_en, 1);
        extra = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R8 no extra done", extra, 0);
        // R9: results held long after the pulse
        check("R9 fact_x held", fact_x, ax);
        check("R9 fact_y held", fact_y, ay);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule